// File: doc/BRIEF.md
# Stereo Audio Transmit Sample Queue

This block sits between a processor's write path and the bit serializer of a stereo audio port. Software hands it 32-bit words, and a two-bit packing mode says how each word is unpacked. Dual stereo mode carries one channel per word. The two compact modes carry both channels in one word, as 16-bit or 8-bit halves. Mono mode carries one sample that plays on both channels. Each sample lands in a 16-entry store of channel samples. The serializer takes the queue out one left/right pair at a time.

The fill level counts channel samples, not words. A stereo pair, or a single mono word, adds two. A lone left sample in dual mode leaves the level odd, so a missing right sample can be seen. A programmable even limit drives a service request, and that request stays high while the level is below the limit. A write the queue cannot take is discarded and raises a sticky error flag.

Top module: `audio_tx_fifo`

## Requirements
- R1: The queue holds at most 16 channel samples. A write is accepted only when the current level plus the samples it carries is at most 16, so level never exceeds 16. For example, a two-sample write at level 15 is refused.
- R2: With `mode`=0 (dual stereo), a write stores all 32 bits of `wr_data` as one sample and adds 1 to the level. Successive samples fill the left slot and then the right slot of each pair.
- R3: With `mode`=1 (16-bit compact), a write stores bits 15:0 as left and bits 31:16 as right, each zero-extended to 32 bits, and adds 2.
- R4: With `mode`=2 (8-bit compact), a write stores bits 7:0 as left and bits 15:8 as right, zero-extended, and adds 2. Bits 31:16 have no effect on the stored samples.
- R5: With `mode`=3 (mono), a write stores `wr_data` as both left and right and adds 2.
- R6: `svc_req` is high exactly while the level is strictly less than the limit. A limit of 0 never requests, and a limit of 16 requests whenever the level is below 16.
- R7: A write on `lim_we` loads `lim_data` with bit 0 forced to 0. `limit` reads back that even value, and it is 0 after reset.
- R8: The level output shows an odd count while a left sample waits for its right. `pop_valid` is high exactly when the level is at least 2.
- R9: A refused write leaves the stored samples and the level unchanged and sets `tx_err`. `tx_err` stays set until reset.
- R10: While `pop_valid` is high, `pop_left`/`pop_right` show the oldest pair. A cycle with `pop_req` high removes that pair, and the level drops by 2. `pop_req` while `pop_valid` is low has no effect.
- R11: A write and a pop in the same cycle are both performed. Acceptance of the write is judged on the level before the pop, and the level changes by the written count minus 2.
- R12: After reset, the level is 0 and `svc_req`, `tx_err` and `pop_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Packing mode: 0 dual, 1 compact 16, 2 compact 8, 3 mono |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Packed write word |
| lim_we | input | 1 | Limit load strobe |
| lim_data | input | 5 | New limit value |
| level | output | 5 | Fill level in channel samples |
| limit | output | 5 | Current limit |
| svc_req | output | 1 | Service request, level below limit |
| tx_err | output | 1 | Sticky refused-write flag |
| pop_req | input | 1 | Serializer takes the head pair |
| pop_valid | output | 1 | A whole pair is available |
| pop_left | output | 32 | Left sample of head pair |
| pop_right | output | 32 | Right sample of head pair |

## Verification
A write and a pop can land in the same cycle. That is the case where the level must move by the written count minus two, and where capacity must be judged before the pop frees space. The bench provokes this at a full queue, where the write must still be refused. It provokes it again at level 14, where both operations must take effect. The behavioural queue model decides acceptance on its size before popping and then compares level, error, request and head pair on the following falling edge.

// File: rtl/audio_txf_pkg.sv
// Shared types for the audio transmit sample queue.
package audio_txf_pkg;
    typedef enum logic [1:0] {
        PK_DUAL = 2'd0,
        PK_C16  = 2'd1,
        PK_C8   = 2'd2,
        PK_MONO = 2'd3
    } pack_mode_e;
endpackage

// File: rtl/audio_txf_unpack.sv
// Splits one packed write word into one or two channel samples.
// Assumes DATA_W >= 16; compact fields are zero-extended.
module audio_txf_unpack
    import audio_txf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              two_units,
    output logic [DATA_W-1:0] unit_a,
    output logic [DATA_W-1:0] unit_b
);
    // Decode the packing mode into sample values and count.
    always_comb begin
        two_units = 1'b1;
        unit_a    = wr_data;
        unit_b    = wr_data;
        case (pack_mode_e'(mode))
            PK_DUAL: begin
                two_units = 1'b0;
            end
            PK_C16: begin
                unit_a = DATA_W'(wr_data[15:0]);
                unit_b = DATA_W'(wr_data[DATA_W-1:16]);
            end
            PK_C8: begin
                unit_a = DATA_W'(wr_data[7:0]);
                unit_b = DATA_W'(wr_data[15:8]);
            end
            default: begin
                unit_a = wr_data;
                unit_b = wr_data;
            end
        endcase
    end
endmodule

// File: rtl/audio_txf_store.sv
// Circular store of channel samples; pushes one or two, pops two.
// Assumes DEPTH is a power of two so pointers wrap naturally, and that
// the caller never overfills or over-drains it.
module audio_txf_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              push_two,
    input  logic [DATA_W-1:0] d_a,
    input  logic [DATA_W-1:0] d_b,
    input  logic              pop,
    output logic [DATA_W-1:0] head_a,
    output logic [DATA_W-1:0] head_b
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [PTR_W-1:0]  wp_nx1, rp_nx1;

    assign wp_nx1 = wp + PTR_W'(1);
    assign rp_nx1 = rp + PTR_W'(1);
    assign head_a = mem[rp];
    assign head_b = mem[rp_nx1];

    // Advance write and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= push_two ? wp + PTR_W'(2) : wp_nx1;
            if (pop)  rp <= rp + PTR_W'(2);
        end
    end

    // Write one or two sample slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wp] <= d_a;
            if (push_two) mem[wp_nx1] <= d_b;
        end
    end
endmodule

// File: rtl/audio_txf_thresh.sv
// Holds the even service limit and compares it with the level.
// Assumes software loads values 0..DEPTH; bit 0 is discarded.
module audio_txf_thresh #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_we,
    input  logic [LVL_W-1:0] lim_data,
    input  logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] limit,
    output logic             svc_req
);
    logic [LVL_W-1:0] lim_q;

    // Load the limit, forcing it even.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_q <= '0;
        else if (lim_we) lim_q <= {lim_data[LVL_W-1:1], 1'b0};
    end

    assign limit   = lim_q;
    assign svc_req = level < lim_q;
endmodule

// File: rtl/audio_tx_fifo.sv
// Audio transmit sample queue: unpacks writes, tracks level in channel
// samples, refuses writes that do not fit, and hands pairs to the
// serializer. Assumes DEPTH is an even power of two.
module audio_tx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lim_we,
    input  logic [LVL_W-1:0]  lim_data,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  limit,
    output logic              svc_req,
    output logic              tx_err,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_left,
    output logic [DATA_W-1:0] pop_right
);
    logic              two_units;
    logic [DATA_W-1:0] unit_a, unit_b;
    logic [LVL_W:0]    after_wr;
    logic              accept, take;
    logic [LVL_W-1:0]  lvl_q;
    logic              err_q;

    audio_txf_unpack #(.DATA_W(DATA_W)) u_unpack (
        .mode      (mode),
        .wr_data   (wr_data),
        .two_units (two_units),
        .unit_a    (unit_a),
        .unit_b    (unit_b)
    );

    assign after_wr  = {1'b0, lvl_q} + (two_units ? (LVL_W+1)'(2) : (LVL_W+1)'(1));
    assign accept    = wr_en && (after_wr <= (LVL_W+1)'(DEPTH));
    assign pop_valid = lvl_q >= LVL_W'(2);
    assign take      = pop_req && pop_valid;

    audio_txf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_two (two_units),
        .d_a      (unit_a),
        .d_b      (unit_b),
        .pop      (take),
        .head_a   (pop_left),
        .head_b   (pop_right)
    );

    // Track the level in channel samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= lvl_q
                   + (accept ? (two_units ? LVL_W'(2) : LVL_W'(1)) : LVL_W'(0))
                   - (take ? LVL_W'(2) : LVL_W'(0));
        end
    end

    // Latch refused writes until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 err_q <= 1'b0;
        else if (wr_en && !accept)  err_q <= 1'b1;
    end

    assign level  = lvl_q;
    assign tx_err = err_q;

    audio_txf_thresh #(.LVL_W(LVL_W)) u_thresh (
        .clk      (clk),
        .rst_n    (rst_n),
        .lim_we   (lim_we),
        .lim_data (lim_data),
        .level    (lvl_q),
        .limit    (limit),
        .svc_req  (svc_req)
    );
endmodule

// File: rtl/audio_txf_chk.sv
// Port-level temporal checks for the audio transmit sample queue.
module audio_txf_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             wr_en,
    input logic             pop_req,
    input logic             pop_valid,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] limit,
    input logic             svc_req,
    input logic             tx_err
);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R2
    dual_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && mode == 2'd0 && level < LVL_W'(DEPTH) && !(pop_req && pop_valid)
        |=> level == $past(level) + LVL_W'(1));

    // R5
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && mode != 2'd0 && level <= LVL_W'(DEPTH - 2) && !(pop_req && pop_valid)
        |=> level == $past(level) + LVL_W'(2));

    // R9
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && level == LVL_W'(DEPTH) && !pop_req
        |=> level == LVL_W'(DEPTH) && tx_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |=> tx_err);

    // R10
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && pop_valid && !wr_en |=> level == $past(level) - LVL_W'(2));

    // R6
    req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        limit == '0 |-> !svc_req);

    // R6
    req_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level == '0 && limit != '0 |-> svc_req);

    // R7
    lim_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !limit[0]);
endmodule

bind audio_tx_fifo audio_txf_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .wr_en     (wr_en),
    .pop_req   (pop_req),
    .pop_valid (pop_valid),
    .level     (level),
    .limit     (limit),
    .svc_req   (svc_req),
    .tx_err    (tx_err)
);

// File: tb/tb_audio_tx_fifo.sv
// Bench: behavioural queue model compared with the design every clock.
module tb_audio_tx_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        lim_we = 1'b0;
    logic [4:0]  lim_data = '0;
    logic        pop_req = 1'b0;
    logic [4:0]  level, limit;
    logic        svc_req, tx_err, pop_valid;
    logic [31:0] pop_left, pop_right;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] q[$];
    int          m_lim = 0;
    bit          m_err = 0;

    always #10 clk = ~clk;

    audio_tx_fifo dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .lim_we(lim_we), .lim_data(lim_data), .level(level), .limit(limit),
        .svc_req(svc_req), .tx_err(tx_err), .pop_req(pop_req), .pop_valid(pop_valid),
        .pop_left(pop_left), .pop_right(pop_right)
    );

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "level", level, q.size());
        chk(tag, "limit", limit, m_lim);
        chk(tag, "svc_req", svc_req, (q.size() < m_lim) ? 1 : 0);
        chk(tag, "tx_err", tx_err, m_err);
        chk(tag, "pop_valid", pop_valid, (q.size() >= 2) ? 1 : 0);
        if (q.size() >= 2) begin
            chk(tag, "pop_left", pop_left, q[0]);
            chk(tag, "pop_right", pop_right, q[1]);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic we, input logic [31:0] wd,
                        input logic pr, input logic lwe, input logic [4:0] ld,
                        input string tag);
        int  n;
        bit  acc, pok;
        mode = m; wr_en = we; wr_data = wd; pop_req = pr; lim_we = lwe; lim_data = ld;
        @(posedge clk);
        n   = (m == 2'd0) ? 1 : 2;
        acc = we && (q.size() + n <= 16);
        pok = pr && (q.size() >= 2);
        if (we && !acc) m_err = 1;
        if (pok) begin void'(q.pop_front()); void'(q.pop_front()); end
        if (acc) begin
            case (m)
                2'd0: q.push_back(wd);
                2'd1: begin q.push_back({16'h0, wd[15:0]}); q.push_back({16'h0, wd[31:16]}); end
                2'd2: begin q.push_back({24'h0, wd[7:0]});  q.push_back({24'h0, wd[15:8]}); end
                default: begin q.push_back(wd); q.push_back(wd); end
            endcase
        end
        if (lwe) m_lim = int'(ld) & ~1;
        @(negedge clk);
        wr_en = 1'b0; pop_req = 1'b0; lim_we = 1'b0;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0, tag);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R12");
        idle("R12");

        // Limit loads are forced even.
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 5'd9, "R7");
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 5'd8, "R7");

        // Dual stereo: left then right, then pop.
        step(2'd0, 1'b1, 32'hA1A1_0001, 1'b0, 1'b0, 5'd0, "R2");
        step(2'd0, 1'b1, 32'hB2B2_0002, 1'b0, 1'b0, 5'd0, "R2");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R10");

        // Lone left leaves an odd level; pop below a pair is ignored.
        step(2'd0, 1'b1, 32'hC3C3_0003, 1'b0, 1'b0, 5'd0, "R8");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R10");
        step(2'd0, 1'b1, 32'hD4D4_0004, 1'b0, 1'b0, 5'd0, "R8");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R10");

        // Compact and mono packing.
        step(2'd1, 1'b1, 32'h1234_5678, 1'b0, 1'b0, 5'd0, "R3");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R3");
        step(2'd2, 1'b1, 32'hFFFF_AB12, 1'b0, 1'b0, 5'd0, "R4");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R4");
        step(2'd3, 1'b1, 32'hCAFE_F00D, 1'b0, 1'b0, 5'd0, "R5");
        step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R5");
        idle("R10");

        // Fill to capacity with mono and compact words.
        for (int i = 0; i < 7; i++)
            step(2'd3 - 2'(i % 2), 1'b1, 32'h100 + 32'(i), 1'b0, 1'b0, 5'd0, "R1");
        step(2'd0, 1'b1, 32'h0000_0E0E, 1'b0, 1'b0, 5'd0, "R8");
        step(2'd1, 1'b1, 32'h5555_6666, 1'b0, 1'b0, 5'd0, "R1");
        step(2'd0, 1'b1, 32'h0000_0F0F, 1'b0, 1'b0, 5'd0, "R1");
        step(2'd0, 1'b1, 32'hDEAD_0001, 1'b0, 1'b0, 5'd0, "R9");
        step(2'd2, 1'b1, 32'hDEAD_0002, 1'b0, 1'b0, 5'd0, "R9");
        idle("R9");

        // Write and pop together at full, then at 14.
        step(2'd1, 1'b1, 32'h7777_8888, 1'b1, 1'b0, 5'd0, "R11");
        step(2'd2, 1'b1, 32'h0000_3C4D, 1'b1, 1'b0, 5'd0, "R11");

        // Request thresholds.
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 5'd16, "R6");
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 5'd0, "R6");
        step(2'd0, 1'b0, 32'h0, 1'b0, 1'b1, 5'd12, "R6");
        for (int i = 0; i < 8; i++) step(2'd0, 1'b0, 32'h0, 1'b1, 1'b0, 5'd0, "R10");
        idle("R6");

        // Reset returns to the idle state.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        q.delete(); m_lim = 0; m_err = 0;
        compare("R12");

        done = 1;
        summary();
        $finish;
    end
endmodule